// File: doc/BRIEF.md
# Addressed-frame asynchronous serial port

This block is a full-duplex asynchronous serial port with a four-word register interface. Each frame has one start bit, eight data bits sent least significant bit first, a ninth bit and one stop bit. The line is timed by a free-running oversampling tick input, with sixteen ticks per bit. In plain format the ninth bit carries even parity. In addressed format it marks the frame as an ID frame (1) or a data frame (0).

When addressed format is on, software can arm a wait. While the wait is armed, the receiver drops every data frame silently. The first ID frame clears the wait and is delivered like an ordinary frame. This lets a station on a shared line ignore traffic meant for others. The transmitter reports when it has run dry through a transmit-end flag, whose interrupt needs a deliberate clear.

Software clears a status flag in two steps: it reads the flag as 1, then writes 0 to it. Three level interrupt requests come out of the block: receive, receive error and transmit end.

Top module: `mpuart`

Register map (`bus_addr`):
- 0, control, read/write: b0 receive enable, b1 ID wait, b2 transmit-end interrupt enable, b3 receive interrupt enable, b4 addressed format, b5 transmit enable, b6 ninth bit to send in addressed format.
- 1, status: b0 receive full, b1 framing error, b2 parity error, b3 overrun, b4 transmit data empty, b5 transmit end, b6 ninth bit of the last stored frame (read only).
- 2, receive data, read only.
- 3, transmit data, read/write.

## Requirements
- R1: A frame is received only when receive enable (control b0) is 1 and the line is still low at the middle of the start bit, eight ticks after the falling edge. With receive enable at 0, or after a shorter low pulse, no status flag changes.
- R2: Writing receive enable to 0 leaves status b0 to b3 unchanged.
- R3: In plain format (control b4 = 0), a stored frame whose ninth bit differs from the XOR of its data bits sets parity error (status b2). In this format the ID wait bit has no effect on reception and is not cleared.
- R4: In addressed format with the ID wait (control b1) at 1, a frame whose ninth bit is 0 changes no status flag and raises no interrupt. This holds even when its stop bit is bad.
- R5: In addressed format with the ID wait at 1, a frame whose ninth bit is 1 clears control b1. It is stored in the receive data register, sets receive full and sets status b6. Later frames are handled normally.
- R6: A frame whose stop bit samples 0 is stored and sets framing error (status b1).
- R7: A frame that completes while receive full is 1 sets overrun (status b3). Its data is discarded and the receive data register keeps its value.
- R8: A status flag clears only when 0 is written to it after a status read that returned it as 1. Writing 0 without such a read, or writing 1, leaves the flag unchanged.
- R9: irq_rx equals receive full AND control b3. irq_err equals (framing OR parity OR overrun) AND control b3.
- R10: With transmit enable (control b5) at 1, clearing transmit data empty starts a frame from the transmit data register. That frame's ninth bit is the parity bit in plain format, or control b6 in addressed format. Starting the frame sets transmit data empty again and clears transmit end.
- R11: When a frame ends with transmit data empty at 1, transmit end (status b5) sets. irq_tend equals transmit end AND control b2, so it is removed either by clearing b2 or by clearing the flag as in R8.
- R12: After reset, txd is 1, status reads 0x30, control reads 0 and all interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling tick, sixteen per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; marks flags as seen |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_rx | output | 1 | Receive request |
| irq_err | output | 1 | Receive error request |
| irq_tend | output | 1 | Transmit-end request |

## Verification
Receive frames are driven with good parity, bad parity, a bad stop bit and back-to-back arrival. These separate the parity, framing and overrun paths from a plain store. Addressed-format runs send a data frame, a data frame with a bad stop bit and then an ID frame, which shows that discarded frames leave no trace and that the wait ends on the right frame. Disabled reception and a short start glitch check start qualification. Transmitted frames in both formats are decoded off the line and compared against a queue, which distinguishes the parity ninth bit from the software-chosen one.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam int NFLAG  = 6;
  localparam int F_RDF  = 0;
  localparam int F_FER  = 1;
  localparam int F_PER  = 2;
  localparam int F_OVR  = 3;
  localparam int F_TDE  = 4;
  localparam int F_TEND = 5;

  localparam int C_RXEN = 0;
  localparam int C_WAIT = 1;
  localparam int C_TEIE = 2;
  localparam int C_RXIE = 3;
  localparam int C_MPF  = 4;
  localparam int C_TXEN = 5;
  localparam int C_TMPB = 6;

  // even parity bit: makes the count of ones over data plus bit even
  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          rx_en,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          stop_ok
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 2);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;
  rx_st_t        st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; bitn <= '0;
      data <= '0; ninth <= 1'b0; stop_ok <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (rx_en && !rxd_s) begin
            st <= RX_START; cnt <= '0;
          end
          RX_START: if (cnt == HALF) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rxd_s ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + 1'b1;
          RX_BITS: if (cnt == FULL) begin
            cnt  <= '0;
            bitn <= bitn + 1'b1;
            if (bitn < BW'(DW)) data <= {rxd_s, data[DW-1:1]};
            else if (bitn == BW'(DW)) ninth <= rxd_s;
            else begin
              stop_ok <= rxd_s;
              done    <= 1'b1;
              st      <= RX_IDLE;
            end
          end else cnt <= cnt + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R1: no frame begins while reception is disabled
  a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && !rx_en) |=> st == RX_IDLE);
endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          ninth,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int CW = $clog2(OVS);
  localparam int NB = DW + 3;
  localparam int BW = $clog2(NB);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  logic [NB-1:0] sh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; cnt <= '0; bitn <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh <= {1'b1, ninth, data, 1'b0};
        cnt <= '0; bitn <= '0; busy <= 1'b1;
      end else if (busy && tick) begin
        if (cnt == FULL) begin
          cnt <= '0;
          sh  <= {1'b1, sh[NB-1:1]};
          if (bitn == BW'(NB - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else bitn <= bitn + 1'b1;
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  assign txd = busy ? sh[0] : 1'b1;

  // R10: a frame always opens with a low start bit
  a_r10_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !txd);
endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs
  import mpuart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_ninth,
  input  logic          rx_stop,
  output logic          rx_en,
  input  logic          tx_busy,
  input  logic          tx_done,
  output logic          tx_start,
  output logic [DW-1:0] tx_data,
  output logic          tx_ninth,
  output logic          irq_rx,
  output logic          irq_err,
  output logic          irq_tend
);
  logic [6:0]       ctl;
  logic [NFLAG-1:0] flg, seen, set_hw, clr_hw, clr_sw, flg_n;
  logic [DW-1:0]    rdr, tdr;
  logic             last_ninth;

  // named events
  logic ctl_wr, stat_wr, stat_rd, waiting, mp_hit, accept, store, ovr_set;
  logic fer_set, per_set;

  assign ctl_wr  = bus_wr && bus_addr == 2'd0;
  assign stat_wr = bus_wr && bus_addr == 2'd1;
  assign stat_rd = bus_rd && bus_addr == 2'd1;
  assign waiting = ctl[C_MPF] && ctl[C_WAIT];
  assign mp_hit  = rx_done && waiting && rx_ninth;
  assign accept  = rx_done && !(waiting && !rx_ninth);
  assign store   = accept && !flg[F_RDF];
  assign ovr_set = accept && flg[F_RDF];
  assign fer_set = store && !rx_stop;
  assign per_set = store && !ctl[C_MPF] && (rx_ninth != even_par(rx_data));

  assign tx_start = ctl[C_TXEN] && !flg[F_TDE] && !tx_busy;
  assign tx_data  = tdr;
  assign tx_ninth = ctl[C_MPF] ? ctl[C_TMPB] : even_par(tdr);

  always_comb begin
    set_hw = '0;
    set_hw[F_RDF]  = store;
    set_hw[F_FER]  = fer_set;
    set_hw[F_PER]  = per_set;
    set_hw[F_OVR]  = ovr_set;
    set_hw[F_TDE]  = tx_start;
    set_hw[F_TEND] = tx_done && flg[F_TDE];
    clr_hw = '0;
    clr_hw[F_TEND] = tx_start;
    clr_sw = stat_wr ? (~bus_wdata[NFLAG-1:0] & seen) : '0;
    flg_n  = (flg & ~clr_sw & ~clr_hw) | set_hw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      flg <= NFLAG'(1) << F_TDE | NFLAG'(1) << F_TEND;
      seen <= '0; rdr <= '0; tdr <= '0; last_ninth <= 1'b0;
    end else begin
      flg  <= flg_n;
      seen <= (seen | (stat_rd ? flg : '0)) & ~clr_sw & ~clr_hw;
      if (ctl_wr) ctl <= bus_wdata[6:0];
      else if (mp_hit) ctl[C_WAIT] <= 1'b0;
      if (bus_wr && bus_addr == 2'd3) tdr <= bus_wdata[DW-1:0];
      if (store) begin
        rdr <= rx_data;
        last_ninth <= rx_ninth;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      2'd0:    bus_rdata = {1'b0, ctl};
      2'd1:    bus_rdata = {1'b0, last_ninth, flg};
      2'd2:    bus_rdata = 8'(rdr);
      default: bus_rdata = 8'(tdr);
    endcase
  end

  assign rx_en    = ctl[C_RXEN];
  assign irq_rx   = flg[F_RDF] && ctl[C_RXIE];
  assign irq_err  = (flg[F_FER] || flg[F_PER] || flg[F_OVR]) && ctl[C_RXIE];
  assign irq_tend = flg[F_TEND] && ctl[C_TEIE];

  // R2: disabling reception leaves receive flags alone
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[C_RXEN] && !rx_done) |=> $stable(flg[3:0]));
  // R4: a dropped data frame leaves no trace
  a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && waiting && !rx_ninth && !stat_wr) |=> $stable(flg[3:0]));
  // R5: ID frame ends the wait and is delivered
  a_r5_id_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && waiting && rx_ninth && !ctl_wr) |=> (!ctl[C_WAIT] && flg[F_RDF]));
  // R7: overrun keeps the held byte
  a_r7_ovr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> (flg[F_OVR] && $stable(rdr)));
  // R11: end of frame with nothing queued raises transmit end
  a_r11_tend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && flg[F_TDE] && !stat_wr) |=> flg[F_TEND]);
endmodule

// File: rtl/mpuart.sv
module mpuart #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       txd,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_rx,
  output logic       irq_err,
  output logic       irq_tend
);
  logic [1:0]    rx_sync;
  logic          rx_en, rx_done, rx_ninth, rx_stop;
  logic [DW-1:0] rx_data, tx_data;
  logic          tx_start, tx_busy, tx_done, tx_ninth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  end

  mpuart_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rx_sync[1]), .rx_en(rx_en),
    .done(rx_done), .data(rx_data), .ninth(rx_ninth), .stop_ok(rx_stop));

  mpuart_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start), .data(tx_data),
    .ninth(tx_ninth), .txd(txd), .busy(tx_busy), .done(tx_done));

  mpuart_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_stop(rx_stop),
    .rx_en(rx_en), .tx_busy(tx_busy), .tx_done(tx_done), .tx_start(tx_start),
    .tx_data(tx_data), .tx_ninth(tx_ninth),
    .irq_rx(irq_rx), .irq_err(irq_err), .irq_tend(irq_tend));
endmodule

// File: tb/sim_mpuart.sv
module sim_mpuart;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic txd, irq_rx, irq_err, irq_tend;
  int n_chk = 0, n_fail = 0, n_frames = 0;
  logic [8:0] exp_q[$];
  logic [7:0] v;

  always #5 clk = ~clk;

  mpuart u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .txd(txd),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_err(irq_err), .irq_tend(irq_tend));

  // tick on every second clock: one bit lasts 32 clocks
  initial forever begin
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // drive one frame onto rxd; stop_len shortens a bad stop bit
  task automatic send_rx(input logic [7:0] d, input logic nb, input logic sb);
    @(negedge clk); rxd = 1'b0;
    repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; repeat (32) @(negedge clk);
    end
    rxd = nb; repeat (32) @(negedge clk);
    rxd = sb; repeat (sb ? 32 : 20) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
  endtask

  // scoreboard monitor for the transmit line
  initial forever begin
    logic [8:0] got;
    @(negedge txd);
    repeat (16) @(posedge clk);
    for (int i = 0; i < 9; i++) begin
      repeat (32) @(posedge clk); got[i] = txd;
    end
    repeat (32) @(posedge clk);
    chk("R10 stop bit", txd, 1'b1);
    n_frames++;
    if (exp_q.size() == 0) chk("R10 unexpected frame", got, 9'h1ff);
    else chk("R10 tx frame", got, exp_q.pop_front());
  end

  initial begin
    #1_500_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1'b1;
    // R12 reset state
    rd(2'd1, v); chk("R12 status", v, 8'h30);
    rd(2'd0, v); chk("R12 control", v, 8'h00);
    chk("R12 txd", txd, 1'b1);
    chk("R12 irqs", {irq_rx, irq_err, irq_tend}, 3'b000);

    // R1: disabled receiver, then a short glitch
    send_rx(8'hA5, 1'b0, 1'b1);
    rd(2'd1, v); chk("R1 disabled no rdf", v[3:0], 4'h0);
    wr(2'd0, 8'h09);
    @(negedge clk); rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (80) @(negedge clk);
    rd(2'd1, v); chk("R1 glitch no rdf", v[3:0], 4'h0);

    // R3/R9 plain format good frame
    send_rx(8'hA5, 1'b0, 1'b1);
    chk("R9 irq_rx", irq_rx, 1'b1);
    rd(2'd1, v); chk("R3 good frame", v[3:0], 4'h1);
    rd(2'd2, v); chk("R3 data", v, 8'hA5);
    wr(2'd1, 8'hFE);
    chk("R9 irq_rx cleared", irq_rx, 1'b0);

    // R3 parity error
    send_rx(8'h01, 1'b0, 1'b1);
    chk("R9 irq_err parity", irq_err, 1'b1);
    rd(2'd1, v); chk("R3 parity flag", v[3:0], 4'h5);
    wr(2'd1, 8'hFA);
    rd(2'd1, v); chk("R8 cleared after read", v[3:0], 4'h0);

    // R8 clear protocol
    send_rx(8'h3C, 1'b0, 1'b1);
    wr(2'd1, 8'h30);
    rd(2'd1, v); chk("R8 write0 without read", v[3:0], 4'h1);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R8 write1 no effect", v[3:0], 4'h1);
    wr(2'd1, 8'hFE);
    rd(2'd1, v); chk("R8 clear", v[5:0], 6'h30);

    // R6 framing error
    send_rx(8'h55, 1'b0, 1'b0);
    rd(2'd1, v); chk("R6 framing flag", v[3:0], 4'h3);
    rd(2'd2, v); chk("R6 data stored", v, 8'h55);
    wr(2'd1, 8'hFC);

    // R7 overrun, R2 disable holds flags
    send_rx(8'h11, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b1);
    rd(2'd1, v); chk("R7 overrun flag", v[3:0], 4'h9);
    rd(2'd2, v); chk("R7 data kept", v, 8'h11);
    chk("R9 irq_err ovr", irq_err, 1'b1);
    wr(2'd0, 8'h08);
    rd(2'd1, v); chk("R2 flags kept", v[3:0], 4'h9);
    rd(2'd1, v); wr(2'd1, 8'hF6);

    // R4/R5 addressed format with wait
    wr(2'd0, 8'h1B);
    send_rx(8'h77, 1'b0, 1'b1);
    send_rx(8'h78, 1'b0, 1'b0);
    rd(2'd1, v); chk("R4 no flags", v[3:0], 4'h0);
    chk("R4 no irqs", {irq_rx, irq_err}, 2'b00);
    rd(2'd0, v); chk("R4 wait kept", v[1], 1'b1);
    send_rx(8'h42, 1'b1, 1'b1);
    rd(2'd0, v); chk("R5 wait cleared", v[1], 1'b0);
    rd(2'd1, v); chk("R5 rdf and ninth", v[6:0], 7'h71);
    rd(2'd2, v); chk("R5 data", v, 8'h42);
    send_rx(8'h99, 1'b0, 1'b1);
    rd(2'd1, v); chk("R5 normal after id", v[3:0], 4'h9);
    wr(2'd1, 8'hF6);

    // R3 wait bit inert in plain format
    wr(2'd0, 8'h0B);
    send_rx(8'h0F, 1'b0, 1'b1);
    rd(2'd1, v); chk("R3 wait inert plain", v[3:0], 4'h1);
    rd(2'd0, v); chk("R3 wait not cleared", v[1], 1'b1);
    wr(2'd1, 8'hFE);

    // R10/R11 transmit, plain format
    wr(2'd0, 8'h24);
    chk("R11 irq_tend idle", irq_tend, 1'b1);
    wr(2'd3, 8'h3A);
    exp_q.push_back({1'b0, 8'h3A});
    rd(2'd1, v); wr(2'd1, 8'hEF);
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R10 tde set tend clr", v[5:4], 2'b01);
    chk("R11 irq_tend low busy", irq_tend, 1'b0);
    repeat (420) @(negedge clk);
    rd(2'd1, v); chk("R11 tend set", v[5], 1'b1);
    chk("R11 irq_tend", irq_tend, 1'b1);

    // addressed format, two frames queued back to back
    wr(2'd0, 8'h74);
    wr(2'd3, 8'hC3);
    exp_q.push_back({1'b1, 8'hC3});
    rd(2'd1, v); wr(2'd1, 8'hEF);
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h34);
    wr(2'd3, 8'h81);
    exp_q.push_back({1'b0, 8'h81});
    rd(2'd1, v); wr(2'd1, 8'hEF);
    repeat (360) @(negedge clk);
    chk("R11 no tend between", irq_tend, 1'b0);
    repeat (420) @(negedge clk);
    chk("R10 frames seen", n_frames, 3);
    chk("R10 queue empty", exp_q.size(), 0);
    chk("R11 irq_tend end", irq_tend, 1'b1);
    wr(2'd0, 8'h20);
    chk("R11 cleared by enable", irq_tend, 1'b0);
    rd(2'd1, v); chk("R11 flag remains", v[5], 1'b1);
    wr(2'd1, 8'hDF);
    rd(2'd1, v); chk("R11 flag cleared", v[5], 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule